// File: doc/BRIEF.md
# Flash Upgrade Command Framer

This block sits behind a byte-wide link receiver. It turns the incoming byte stream into flash upgrade commands. While idle it looks for a four-byte signature followed by an opcode, which selects a program pass or a verify pass. It then collects a little-endian start offset and a block count, and checks both against the flash geometry. For each block it forwards the payload as 32-bit words to a downstream buffer and keeps a running sum of those words. It compares that sum with the checksum word that closes the block.

Block events are reported as single-cycle pulses. Errors latch into a 3-bit code until an external restart button is pressed. After each good block, the framer stops taking bytes until the downstream side reports that the block is done. Block and flash sizes are parameters given as powers of two in bytes. The defaults are a 256 KiB block and a 16 MiB flash.

States and transitions:
- HUNT steps through the signature and goes to OPCODE when the fourth byte matches.
- OPCODE goes to OFFSET on a valid opcode, or back to HUNT on any other byte.
- OFFSET goes to COUNT, or to ERROR on a bad offset.
- COUNT goes to PAYLOAD, or to ERROR on a bad count.
- PAYLOAD goes to CSUM after the last word of the block.
- CSUM goes to WAIT on a match, or to ERROR on a mismatch.
- WAIT goes to PAYLOAD for the next block, to HUNT after the last block, or to ERROR on a downstream failure.
- ERROR goes to HUNT on the button.

Top module: `fw_upgrade_framer`

## Requirements
- R1: After reset, rx_ready is 1, err_code is 0, and word_valid, blk_start, blk_good and cmd_end are 0.
- R2: A command header is the byte sequence 0x4D, 0x50, 0x54, 0x21 ("MPT!") in that order. A byte that does not match the expected signature byte is discarded, and matching restarts with the first signature byte at the next byte.
- R3: The byte after the signature is the opcode. 0x50 ('P') selects program (cmd_verify=0) and 0x56 ('V') selects verify (cmd_verify=1). Any other value returns to hunting with err_code left at 0.
- R4: The start offset arrives as four bytes, least significant first. If it is not below the flash size, or not a multiple of the block size, err_code becomes 1 (offset error). This happens before the count byte is taken.
- R5: The next byte is the block count. If it is zero, or if offset + count × block size exceeds the flash size, err_code becomes 2 (count error). A range that ends exactly at the flash size is accepted.
- R6: Each block begins with a one-cycle blk_start pulse, with blk_addr equal to offset + index × block size. Every four payload bytes, least significant first, form one word on word_data with a one-cycle word_valid pulse. A block holds block size / 4 words.
- R7: The word after a block's payload is compared with the modulo-2^32 sum of that block's payload words. On a match, blk_good pulses. On a mismatch, err_code becomes 3 (checksum error) and blk_good does not pulse.
- R8: From blk_good until ds_done, rx_ready is 0. If ds_fail is high together with ds_done, err_code becomes 4 (downstream failure).
- R9: While err_code is nonzero it holds its value and rx_ready is 0. A high restart_btn clears err_code to 0 and resumes hunting with rx_ready 1.
- R10: When ds_done arrives without ds_fail for the last block, cmd_end pulses for one cycle and the framer hunts for a new header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Receiver has a byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Framer accepts a byte this cycle |
| restart_btn | input | 1 | Restart button, leaves the error state |
| ds_done | input | 1 | Downstream finished the current block |
| ds_fail | input | 1 | Downstream failed, sampled with ds_done |
| cmd_verify | output | 1 | 1 for a verify command, 0 for program |
| blk_start | output | 1 | Pulse at the start of each block |
| blk_addr | output | 32 | Byte offset of the current block |
| word_valid | output | 1 | Pulse, word_data holds a payload word |
| word_data | output | 32 | Payload word |
| blk_good | output | 1 | Pulse, block checksum matched |
| cmd_end | output | 1 | Pulse, last block of the command finished |
| err_code | output | 3 | 0 none, 1 offset, 2 count, 3 checksum, 4 downstream |

## Verification
The hardest situations to reach are the ones deep in a command: a checksum mismatch or a downstream failure on a block that is neither the first nor the last. Reaching them needs a correct header, legal parameters and whole earlier blocks, each with a valid checksum. The bench builds every command from generated payload and computes each block's sum. It then corrupts only a chosen block's checksum, or raises the downstream failure only on a chosen block. The bench also runs the boundary ranges that end exactly at the top of the flash, and header streams where a partial signature is cut off by a repeated first byte.

// File: rtl/fwu_pkg.sv
package fwu_pkg;

    typedef enum logic [3:0] {
        ST_HUNT,
        ST_OPCODE,
        ST_OFFSET,
        ST_COUNT,
        ST_PAYLOAD,
        ST_CSUM,
        ST_WAIT,
        ST_ERROR
    } fw_state_t;

    typedef enum logic [2:0] {
        ERR_NONE       = 3'd0,
        ERR_OFFSET     = 3'd1,
        ERR_COUNT      = 3'd2,
        ERR_CSUM       = 3'd3,
        ERR_DOWNSTREAM = 3'd4
    } fw_err_t;

    localparam logic [7:0] OP_PROGRAM = 8'h50;
    localparam logic [7:0] OP_VERIFY  = 8'h56;

    function automatic logic [7:0] sig_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    sig_byte = 8'h4D;
            2'd1:    sig_byte = 8'h50;
            2'd2:    sig_byte = 8'h54;
            default: sig_byte = 8'h21;
        endcase
    endfunction

endpackage

// File: rtl/fw_word_asm.sv
module fw_word_asm (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        take,
    input  logic [7:0]  byte_in,
    output logic [31:0] word,
    output logic        done
);
    logic [23:0] sh;
    logic [1:0]  cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (take) begin
            sh  <= {byte_in, sh[23:8]};
            cnt <= cnt + 2'd1;
        end
    end

    // little-endian: the byte completing the word is the most significant
    assign word = {byte_in, sh};
    assign done = take && !clear && (cnt == 2'd3);
endmodule

// File: rtl/fw_csum.sv
module fw_csum (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        add,
    input  logic [31:0] word,
    output logic [31:0] sum
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sum <= '0;
        else if (clear) sum <= '0;
        else if (add)   sum <= sum + word;
    end
endmodule

// File: rtl/fw_range_chk.sv
module fw_range_chk #(
    parameter int BLK_LOG2   = 18,
    parameter int FLASH_LOG2 = 24,
    parameter int CNT_W      = 8
) (
    input  logic [31:0]      chk_off,
    input  logic [31:0]      base_off,
    input  logic [CNT_W-1:0] chk_cnt,
    output logic             off_bad,
    output logic             cnt_bad
);
    localparam int SUM_W = 34 + CNT_W;
    localparam logic [SUM_W-1:0] FLASH_BYTES = SUM_W'(1) << FLASH_LOG2;

    logic [SUM_W-1:0] end_addr;

    assign end_addr = SUM_W'(base_off) + (SUM_W'(chk_cnt) << BLK_LOG2);
    assign off_bad  = (SUM_W'(chk_off) >= FLASH_BYTES) || (chk_off[BLK_LOG2-1:0] != '0);
    assign cnt_bad  = (chk_cnt == '0) || (end_addr > FLASH_BYTES);
endmodule

// File: rtl/fw_upgrade_framer.sv
module fw_upgrade_framer
    import fwu_pkg::*;
#(
    parameter int BLK_LOG2   = 18,
    parameter int FLASH_LOG2 = 24,
    parameter int CNT_W      = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        rx_ready,
    input  logic        restart_btn,
    input  logic        ds_done,
    input  logic        ds_fail,
    output logic        cmd_verify,
    output logic        blk_start,
    output logic [31:0] blk_addr,
    output logic        word_valid,
    output logic [31:0] word_data,
    output logic        blk_good,
    output logic        cmd_end,
    output logic [2:0]  err_code
);
    localparam int WORDS_LOG2 = BLK_LOG2 - 2;
    localparam logic [WORDS_LOG2-1:0] LAST_WORD = '1;
    localparam logic [31:0] BLK_BYTES = 32'(1) << BLK_LOG2;

    fw_state_t state, nstate;
    logic [1:0]            sig_idx;
    logic [31:0]           off_q;
    logic [CNT_W-1:0]      remain;
    logic [WORDS_LOG2-1:0] widx;
    logic                  take, asm_clear, word_done;
    logic [31:0]           word, sum;
    logic                  off_bad, cnt_bad, sum_clear, sum_add;

    assign rx_ready  = (state != ST_WAIT) && (state != ST_ERROR);
    assign take      = rx_valid && rx_ready;
    assign asm_clear = !(state inside {ST_OFFSET, ST_PAYLOAD, ST_CSUM});
    assign sum_clear = !(state inside {ST_PAYLOAD, ST_CSUM});
    assign sum_add   = (state == ST_PAYLOAD) && word_done;

    fw_word_asm u_asm (
        .clk(clk), .rst_n(rst_n), .clear(asm_clear), .take(take),
        .byte_in(rx_data), .word(word), .done(word_done)
    );

    fw_csum u_sum (
        .clk(clk), .rst_n(rst_n), .clear(sum_clear), .add(sum_add),
        .word(word), .sum(sum)
    );

    fw_range_chk #(.BLK_LOG2(BLK_LOG2), .FLASH_LOG2(FLASH_LOG2), .CNT_W(CNT_W)) u_rng (
        .chk_off(word), .base_off(off_q), .chk_cnt(rx_data[CNT_W-1:0]),
        .off_bad(off_bad), .cnt_bad(cnt_bad)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nstate;
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            ST_HUNT:    if (take && rx_data == sig_byte(sig_idx) && sig_idx == 2'd3)
                            nstate = ST_OPCODE;
            ST_OPCODE:  if (take)
                            nstate = (rx_data == OP_PROGRAM || rx_data == OP_VERIFY)
                                     ? ST_OFFSET : ST_HUNT;
            ST_OFFSET:  if (word_done) nstate = off_bad ? ST_ERROR : ST_COUNT;
            ST_COUNT:   if (take) nstate = cnt_bad ? ST_ERROR : ST_PAYLOAD;
            ST_PAYLOAD: if (word_done && widx == LAST_WORD) nstate = ST_CSUM;
            ST_CSUM:    if (word_done) nstate = (word == sum) ? ST_WAIT : ST_ERROR;
            ST_WAIT:    if (ds_done) begin
                            if (ds_fail)                   nstate = ST_ERROR;
                            else if (remain == CNT_W'(1))  nstate = ST_HUNT;
                            else                           nstate = ST_PAYLOAD;
                        end
            ST_ERROR:   if (restart_btn) nstate = ST_HUNT;
            default:    nstate = ST_HUNT;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_idx    <= '0;
            off_q      <= '0;
            remain     <= '0;
            widx       <= '0;
            cmd_verify <= 1'b0;
            blk_start  <= 1'b0;
            blk_addr   <= '0;
            word_valid <= 1'b0;
            word_data  <= '0;
            blk_good   <= 1'b0;
            cmd_end    <= 1'b0;
            err_code   <= ERR_NONE;
        end else begin
            blk_start  <= 1'b0;
            word_valid <= 1'b0;
            blk_good   <= 1'b0;
            cmd_end    <= 1'b0;
            unique case (state)
                ST_HUNT:
                    if (take)
                        sig_idx <= (rx_data == sig_byte(sig_idx)) ? sig_idx + 2'd1 : 2'd0;
                ST_OPCODE:
                    if (take) cmd_verify <= (rx_data == OP_VERIFY);
                ST_OFFSET:
                    if (word_done) begin
                        off_q <= word;
                        if (off_bad) err_code <= ERR_OFFSET;
                    end
                ST_COUNT:
                    if (take) begin
                        remain <= rx_data[CNT_W-1:0];
                        if (cnt_bad) begin
                            err_code <= ERR_COUNT;
                        end else begin
                            blk_start <= 1'b1;
                            blk_addr  <= off_q;
                            widx      <= '0;
                        end
                    end
                ST_PAYLOAD:
                    if (word_done) begin
                        word_valid <= 1'b1;
                        word_data  <= word;
                        widx       <= widx + 1'b1;
                    end
                ST_CSUM:
                    if (word_done) begin
                        if (word == sum) blk_good <= 1'b1;
                        else             err_code <= ERR_CSUM;
                    end
                ST_WAIT:
                    if (ds_done) begin
                        if (ds_fail) begin
                            err_code <= ERR_DOWNSTREAM;
                        end else if (remain == CNT_W'(1)) begin
                            cmd_end <= 1'b1;
                        end else begin
                            remain    <= remain - 1'b1;
                            blk_addr  <= blk_addr + BLK_BYTES;
                            blk_start <= 1'b1;
                            widx      <= '0;
                        end
                    end
                ST_ERROR:
                    if (restart_btn) begin
                        err_code <= ERR_NONE;
                        sig_idx  <= '0;
                    end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fw_framer_checker.sv
module fw_framer_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic       restart_btn,
    input logic       word_valid,
    input logic       blk_start,
    input logic       blk_good,
    input logic       cmd_end,
    input logic [2:0] err_code
);
    a_r9_error_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 3'd0) |-> !rx_ready);

    a_r9_error_held: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 3'd0 && !restart_btn) |=> (err_code == $past(err_code)));

    a_r6_word_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(rx_valid && rx_ready));

    a_r7_good_clean: assert property (@(posedge clk) disable iff (!rst_n)
        blk_good |-> (err_code == 3'd0));

    a_r8_stall_after_good: assert property (@(posedge clk) disable iff (!rst_n)
        blk_good |-> !rx_ready);

    a_r10_end_resumes: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_end |-> (rx_ready && err_code == 3'd0));

    a_r6_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({word_valid, blk_start, blk_good, cmd_end}));
endmodule

bind fw_upgrade_framer fw_framer_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .restart_btn(restart_btn), .word_valid(word_valid), .blk_start(blk_start),
    .blk_good(blk_good), .cmd_end(cmd_end), .err_code(err_code)
);

// File: tb/sim_fw_upgrade_framer.sv
module sim_fw_upgrade_framer;
    localparam int CLK_PERIOD = 10;
    localparam int BLK_LOG2   = 4;
    localparam int FLASH_LOG2 = 8;
    localparam int WPB        = 1 << (BLK_LOG2 - 2);
    localparam int BLK_BYTES  = 1 << BLK_LOG2;
    localparam int FLASH      = 1 << FLASH_LOG2;

    logic        clk = 0, rst_n = 0;
    logic        rx_valid = 0;
    logic [7:0]  rx_data = 0;
    logic        rx_ready, restart_btn = 0, ds_done = 0, ds_fail = 0;
    logic        cmd_verify, blk_start, word_valid, blk_good, cmd_end;
    logic [31:0] blk_addr, word_data;
    logic [2:0]  err_code;

    fw_upgrade_framer #(.BLK_LOG2(BLK_LOG2), .FLASH_LOG2(FLASH_LOG2), .CNT_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .restart_btn(restart_btn), .ds_done(ds_done),
        .ds_fail(ds_fail), .cmd_verify(cmd_verify), .blk_start(blk_start),
        .blk_addr(blk_addr), .word_valid(word_valid), .word_data(word_data),
        .blk_good(blk_good), .cmd_end(cmd_end), .err_code(err_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0, n_fail = 0;
    int n_start = 0, n_good = 0, n_end = 0, r8_viol = 0;
    int ds_wait = -1, ds_delay = 2;
    bit ds_fail_next = 0;
    logic [31:0] got_q[$], addr_q[$], exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor and downstream model
    always @(negedge clk) begin
        ds_done = 0;
        if (word_valid) got_q.push_back(word_data);
        if (blk_start) begin n_start++; addr_q.push_back(blk_addr); end
        if (blk_good) n_good++;
        if (cmd_end) n_end++;
        if (ds_wait >= 0 && rx_ready) r8_viol++;
        if (blk_good) ds_wait = ds_delay;
        else if (ds_wait > 0) ds_wait--;
        else if (ds_wait == 0) begin
            ds_done = 1; ds_fail = ds_fail_next; ds_wait = -1;
        end
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1; rx_data = b;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic try_byte(input logic [7:0] b, output bit ok);
        ok = 0;
        @(negedge clk);
        rx_valid = 1; rx_data = b;
        for (int i = 0; i < 10; i++) begin
            if (rx_ready) begin ok = 1; break; end
            @(negedge clk);
        end
        if (ok) @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int i = 0; i < 4; i++) send_byte(w[8*i +: 8]);
    endtask

    task automatic send_header(input logic [7:0] op);
        send_byte(8'h4D); send_byte(8'h50); send_byte(8'h54); send_byte(8'h21);
        send_byte(op);
    endtask

    task automatic press_button();
        @(negedge clk); restart_btn = 1;
        @(negedge clk); restart_btn = 0;
        chk(err_code == 0 && rx_ready, "R9", "restart clears error", err_code, 0);
    endtask

    function automatic bit off_ok(input logic [31:0] off);
        return off < FLASH && (off % BLK_BYTES) == 0;
    endfunction

    function automatic bit cnt_ok(input logic [31:0] off, input int cnt);
        return cnt != 0 && (longint'(off) + longint'(cnt) * BLK_BYTES) <= FLASH;
    endfunction

    task automatic run_cmd(input logic [7:0] op, input logic [31:0] off, input int cnt,
                           input int bad_blk, input int fail_blk);
        int ng0, ne0;
        logic [31:0] s, w;
        bit ok;
        ng0 = n_good; ne0 = n_end;
        got_q.delete(); addr_q.delete(); exp_q.delete();
        send_header(op);
        send_word(off);
        if (!off_ok(off)) begin
            chk(err_code == 1, "R4", "offset error code", err_code, 1);
            try_byte(8'd1, ok);
            chk(!ok && err_code == 1, "R9", "count byte refused in error", ok, 0);
            press_button();
            return;
        end
        send_byte(8'(cnt));
        if (!cnt_ok(off, cnt)) begin
            chk(err_code == 2, "R5", "count error code", err_code, 2);
            press_button();
            return;
        end
        for (int b = 0; b < cnt; b++) begin
            s = 0;
            ds_fail_next = (b == fail_blk);
            for (int i = 0; i < WPB; i++) begin
                w = $urandom;
                exp_q.push_back(w);
                s += w;
                send_word(w);
            end
            send_word(b == bad_blk ? s + 32'd1 : s);
            if (b == bad_blk) begin
                chk(err_code == 3, "R7", "checksum error code", err_code, 3);
                chk(n_good - ng0 == b, "R7", "no good pulse on bad sum", n_good - ng0, b);
                press_button();
                return;
            end
            repeat (12) @(negedge clk);
            if (b == fail_blk) begin
                chk(err_code == 4, "R8", "downstream failure code", err_code, 4);
                ds_fail_next = 0;
                press_button();
                return;
            end
        end
        chk(got_q.size() == exp_q.size(), "R6", "word count", got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            if (got_q[i] != exp_q[i]) begin
                chk(0, "R6", "payload word", got_q[i], exp_q[i]);
                break;
            end
        for (int i = 0; i < cnt && i < addr_q.size(); i++)
            if (addr_q[i] != off + i * BLK_BYTES) begin
                chk(0, "R6", "block address", addr_q[i], off + i * BLK_BYTES);
                break;
            end
        chk(addr_q.size() == cnt, "R6", "block starts", addr_q.size(), cnt);
        chk(n_good - ng0 == cnt, "R7", "good pulses", n_good - ng0, cnt);
        chk(n_end - ne0 == 1 && rx_ready && err_code == 0, "R10", "command end", n_end - ne0, 1);
        chk(cmd_verify == (op == 8'h56), "R3", "opcode mode", cmd_verify, op == 8'h56);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int s0;
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        chk(rx_ready && err_code == 0 && !word_valid && !blk_start && !blk_good && !cmd_end,
            "R1", "reset state", {rx_ready, err_code}, 4'b1000);
        rst_n = 1;
        @(negedge clk);
        chk(rx_ready && err_code == 0, "R1", "after reset release", err_code, 0);

        // directed: program two blocks
        run_cmd(8'h50, 32'h20, 2, -1, -1);
        // R2: broken headers produce no command
        s0 = n_start;
        send_byte(8'h4D); send_byte(8'h4D); send_byte(8'h50); send_byte(8'h54);
        send_byte(8'h21); send_byte(8'h56);
        send_byte(8'h4D); send_byte(8'h50); send_byte(8'h58);
        repeat (4) @(negedge clk);
        chk(n_start == s0 && err_code == 0 && rx_ready, "R2", "broken signature ignored", n_start - s0, 0);
        // R3: unknown opcode returns to hunting
        send_header(8'h51);
        send_word(32'h0);
        send_byte(8'd1);
        repeat (4) @(negedge clk);
        chk(n_start == s0 && err_code == 0 && rx_ready, "R3", "bad opcode ignored", n_start - s0, 0);
        // verify command
        run_cmd(8'h56, 32'h0, 3, -1, -1);
        // R4 offset errors
        run_cmd(8'h50, 32'h24, 1, -1, -1);
        run_cmd(8'h56, FLASH, 1, -1, -1);
        run_cmd(8'h50, 32'h8000_0000, 1, -1, -1);
        // R5 count boundaries
        run_cmd(8'h50, FLASH - BLK_BYTES, 1, -1, -1);
        run_cmd(8'h50, FLASH - BLK_BYTES, 2, -1, -1);
        run_cmd(8'h50, 32'h0, 0, -1, -1);
        run_cmd(8'h56, 32'h0, 16, -1, -1);
        // R7 checksum on a middle block, R8 failure on a middle block
        run_cmd(8'h50, 32'h10, 3, 1, -1);
        ds_delay = 5;
        run_cmd(8'h50, 32'h10, 3, -1, 1);

        // constrained random
        for (int k = 0; k < 14; k++) begin
            int blk, cnt;
            logic [31:0] off;
            blk = $urandom_range(0, 15);
            cnt = $urandom_range(1, 16 - blk);
            off = blk * BLK_BYTES;
            if ($urandom_range(0, 5) == 0) off = off + $urandom_range(1, 15);
            if ($urandom_range(0, 5) == 0) cnt = cnt + 16;
            ds_delay = $urandom_range(0, 6);
            run_cmd($urandom_range(0, 1) ? 8'h56 : 8'h50, off, cnt,
                    ($urandom_range(0, 6) == 0) ? $urandom_range(0, cnt - 1) : -1, -1);
        end

        chk(r8_viol == 0, "R8", "input stalled while waiting", r8_viol, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule